// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers interrupt requests from a set of devices and offers the most urgent one to a processor. Each source is tied to a fixed binary priority level, set at build time. A request is latched as pending when its device pulses its request line, and it stays pending until the processor takes it. A combinational `irq` output tells the processor that at least one pending request may be taken.

The processor pulses `boundary` between instructions. If `irq` is high at that edge, the block freezes the winning source. The processor then raises `vec_req`, and the block answers one cycle later with a `vec_valid` pulse and the source number on `vec_num`. When a level-K source is accepted, the current mask is pushed on an internal stack and replaced by a mask that blocks level K and every lower level. Interrupts therefore nest strictly by priority. A `reti` pulse pops the saved mask back in one cycle. Software can write the mask and a global enable through a small write port.

Top module: `prio_intc`

## Requirements
- R1: After reset `irq`, `vec_valid`, `intr_en`, `ovf` and `unf` are 0, and `mask` is 0.
- R2: A one-cycle pulse on `dev_req[i]` makes source i pending until it is accepted. `irq` is high exactly when `intr_en` is 1 and some pending source has a level greater than or equal to `mask`. `mask` value m blocks levels below m: 0 blocks nothing, and 8 blocks all eight levels.
- R3: Among the eligible sources the highest level wins (7 highest, 0 lowest). Among equal levels the lower source index wins. The default levels, for sources 0 to 7, are 2, 5, 5, 1, 7, 0, 3, 7.
- R4: The winner is captured only at a clock edge where `boundary` and `irq` are both high, and it is not changed by later requests. `vec_req` with nothing captured produces no `vec_valid`.
- R5: `vec_req` after a capture makes `vec_valid` high for exactly the next cycle, with the captured source on `vec_num`. At the same edge `mask` becomes K+1, where K is that source's level, and the previous mask is pushed.
- R6: The accepted source's pending bit clears at that edge, unless a new pulse on the same source arrives in the same cycle. In that case the source stays pending.
- R7: `reti` with a non-empty stack restores the most recently pushed mask in one cycle.
- R8: `reti` with an empty stack leaves `mask` unchanged and sets the sticky `unf` flag.
- R9: The stack holds 8 masks. An accept made while the stack is full still raises the mask but saves nothing, and it sets the sticky `ovf` flag.
- R10: `cfg_wr` loads `mask` from `cfg_mask` and `intr_en` from `cfg_en`. In a cycle where several apply, an accept takes precedence over `reti`, and `reti` takes precedence over `cfg_wr`. A lower-precedence action in that cycle is ignored entirely.
- R11: While `intr_en` is 0, `irq` stays low, and no capture takes place, even with pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_SRC | Request pulses, one per source |
| boundary | input | 1 | Instruction-boundary strobe |
| vec_req | input | 1 | Vector request from the processor |
| reti | input | 1 | Return-from-interrupt pulse |
| cfg_wr | input | 1 | Software write strobe |
| cfg_en | input | 1 | Global enable value to write |
| cfg_mask | input | LVL_W+1 | Mask value to write |
| irq | output | 1 | An eligible request is pending |
| vec_valid | output | 1 | One-cycle vector answer strobe |
| vec_num | output | clog2(N_SRC) | Accepted source number |
| mask | output | LVL_W+1 | Current mask; levels below it are blocked |
| intr_en | output | 1 | Global enable |
| ovf | output | 1 | Sticky stack-overflow flag |
| unf | output | 1 | Sticky stack-underflow flag |

## Verification
The assertions check, on every cycle, that:
- a returned vector always names a source whose level is now blocked by the mask;
- the vector strobe lasts one cycle;
- the stack pointer never passes its depth;
- both error flags stay set once set;
- a `reti` on an empty stack leaves the mask unchanged;
- an acknowledged source is cleared unless it was re-posted in the same cycle.

Only the directed scenarios can show the following:
- which source wins a tie;
- that a capture is frozen at the boundary;
- that nested accepts and returns restore masks in reverse order;
- the precedence among accept, return and software write;
- that a full stack drops the save while still raising the mask.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_SRC   = 8,
  parameter int LVL_W   = 3,
  parameter int STACK_D = 8,
  parameter logic [N_SRC*LVL_W-1:0] SRC_LVL =
    {3'd7, 3'd3, 3'd0, 3'd7, 3'd1, 3'd5, 3'd5, 3'd2}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           dev_req,
  input  logic                       boundary,
  input  logic                       vec_req,
  input  logic                       reti,
  input  logic                       cfg_wr,
  input  logic                       cfg_en,
  input  logic [LVL_W:0]             cfg_mask,
  output logic                       irq,
  output logic                       vec_valid,
  output logic [$clog2(N_SRC)-1:0]   vec_num,
  output logic [LVL_W:0]             mask,
  output logic                       intr_en,
  output logic                       ovf,
  output logic                       unf
);
  localparam int MW  = LVL_W + 1;
  localparam int IW  = $clog2(N_SRC);
  localparam int SPW = $clog2(STACK_D + 1);
  localparam int SIW = (STACK_D > 1) ? $clog2(STACK_D) : 1;

  function automatic logic [LVL_W-1:0] lvl_of(input logic [IW-1:0] id);
    return SRC_LVL[id*LVL_W +: LVL_W];
  endfunction

  logic [N_SRC-1:0] pend, elig;
  logic             claimed;
  logic [IW-1:0]    held, win_id;
  logic [SPW-1:0]   sp;
  logic [MW-1:0]    stk [STACK_D];
  logic [SIW-1:0]   wr_i, rd_i;
  logic             acc;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = pend[i] && ({1'b0, SRC_LVL[i*LVL_W +: LVL_W]} >= mask);
  end

  always_comb begin
    logic             found;
    logic [LVL_W-1:0] best;
    found  = 1'b0;
    best   = '0;
    win_id = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found || lvl_of(IW'(i)) > best)) begin
        found  = 1'b1;
        best   = lvl_of(IW'(i));
        win_id = IW'(i);
      end
    end
  end

  assign irq  = intr_en && (|elig);
  assign acc  = vec_req && claimed;
  assign wr_i = SIW'(sp);
  assign rd_i = SIW'(sp - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      claimed   <= 1'b0;
      held      <= '0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
      mask      <= '0;
      intr_en   <= 1'b0;
      sp        <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      pend      <= (pend & ~(acc ? (N_SRC'(1) << held) : '0)) | dev_req;
      vec_valid <= acc;
      if (acc) begin
        vec_num <= held;
        claimed <= 1'b0;
      end else if (boundary && irq && !claimed) begin
        claimed <= 1'b1;
        held    <= win_id;
      end
      if (acc) begin
        mask <= MW'({1'b0, lvl_of(held)}) + 1'b1;
        if (sp == SPW'(STACK_D)) ovf <= 1'b1;
        else begin
          stk[wr_i] <= mask;
          sp        <= sp + 1'b1;
        end
      end else if (reti) begin
        if (sp == '0) unf <= 1'b1;
        else begin
          mask <= stk[rd_i];
          sp   <= sp - 1'b1;
        end
      end else if (cfg_wr) begin
        mask    <= cfg_mask;
        intr_en <= cfg_en;
      end
    end
  end

  assert_vec_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ({1'b0, lvl_of(vec_num)} < mask));
  assert_vec_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (pend[$past(held)] == $past(dev_req[held])));
  assert_empty_reti_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !acc && sp == '0) |=> (mask == $past(mask)));
  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_sp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(STACK_D));
endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic clk = 0, rst_n = 0;
  logic [7:0] dev_req = '0;
  logic boundary = 0, vec_req = 0, reti = 0, cfg_wr = 0, cfg_en = 0;
  logic [3:0] cfg_mask = '0;
  logic irq, vec_valid, intr_en, ovf, unf;
  logic [2:0] vec_num;
  logic [3:0] mask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_intc u0 (.clk, .rst_n, .dev_req, .boundary, .vec_req, .reti, .cfg_wr,
                .cfg_en, .cfg_mask, .irq, .vec_valid, .vec_num, .mask,
                .intr_en, .ovf, .unf);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic post(logic [7:0] m); dev_req = m; tick(); dev_req = '0; endtask
  task automatic cfg(logic e, logic [3:0] m);
    cfg_wr = 1; cfg_en = e; cfg_mask = m; tick(); cfg_wr = 0;
  endtask
  task automatic ret(); reti = 1; tick(); reti = 0; endtask
  task automatic take(int exp_id, int exp_mask, string req);
    boundary = 1; tick(); boundary = 0;
    vec_req = 1; tick(); vec_req = 0;
    chk({req, " vec_valid"}, vec_valid, 1);
    chk({req, " vec_num"}, vec_num, exp_id);
    chk({req, " mask"}, mask, exp_mask);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0); chk("R1 vec_valid", vec_valid, 0);
    chk("R1 mask", mask, 0); chk("R1 intr_en", intr_en, 0);
    chk("R1 ovf", ovf, 0); chk("R1 unf", unf, 0);
  endtask

  task automatic t_enable();
    post(8'h08);
    chk("R11 irq while disabled", irq, 0);
    boundary = 1; tick(); boundary = 0;
    vec_req = 1; tick(); vec_req = 0;
    chk("R11 no capture while disabled", vec_valid, 0);
    cfg(1, 0);
    chk("R10 enable written", intr_en, 1);
    chk("R2 irq pending level1", irq, 1);
  endtask

  task automatic t_nest();
    post(8'h06);
    take(1, 6, "R3 tie lower index");
    tick(); chk("R5 vec_valid one cycle", vec_valid, 0);
    chk("R5 lower levels blocked", irq, 0);
    post(8'h10);
    chk("R2 higher level eligible", irq, 1);
    take(4, 8, "R3 nested level7");
    ret(); chk("R7 pop to 6", mask, 6);
    ret(); chk("R7 pop to 0", mask, 0);
    chk("R2 still pending", irq, 1);
    take(2, 6, "R3 level5 over level1");
    ret(); take(3, 2, "R3 last pending");
    ret(); chk("R2 all cleared", irq, 0);
  endtask

  task automatic t_boundary();
    vec_req = 1; tick(); vec_req = 0; tick();
    chk("R4 vec_req without capture", vec_valid, 0);
    post(8'h01);
    boundary = 1; tick(); boundary = 0;
    post(8'h80);
    vec_req = 1; tick(); vec_req = 0;
    chk("R4 frozen winner", vec_num, 0);
    chk("R5 mask level2", mask, 3);
    take(7, 8, "R4 later request");
    ret(); ret(); chk("R7 back to 0", mask, 0);
  endtask

  task automatic t_same();
    post(8'h40);
    boundary = 1; tick(); boundary = 0;
    vec_req = 1; dev_req = 8'h40; tick(); vec_req = 0; dev_req = '0;
    chk("R6 vec_num", vec_num, 6);
    chk("R5 mask level3", mask, 4);
    ret();
    chk("R6 repost kept pending", irq, 1);
    take(6, 4, "R6 retaken");
    ret();
    chk("R6 cleared afterwards", irq, 0);
  endtask

  task automatic t_underflow();
    cfg(1, 5);
    ret();
    chk("R8 mask unchanged", mask, 5);
    chk("R8 unf set", unf, 1);
    tick(); chk("R8 unf sticky", unf, 1);
    cfg(1, 0);
  endtask

  task automatic t_prec();
    post(8'h08); take(3, 2, "R10 setup");
    cfg_wr = 1; cfg_en = 1; cfg_mask = 7; reti = 1; tick();
    cfg_wr = 0; reti = 0;
    chk("R10 reti over write", mask, 0);
    post(8'h01);
    boundary = 1; tick(); boundary = 0;
    vec_req = 1; reti = 1; tick(); vec_req = 0; reti = 0;
    chk("R10 accept over reti", mask, 3);
    ret(); chk("R10 single pop left", mask, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++) begin
      post(8'h20);
      take(5, 1, "R9 push");
      chk("R9 ovf", ovf, (i == 8) ? 1 : 0);
      cfg(1, 0);
    end
    tick(); chk("R9 ovf sticky", ovf, 1);
    for (int i = 0; i < 8; i++) begin
      cfg(1, 7); ret();
      chk("R9 saved mask", mask, 0);
    end
    cfg(1, 7); ret();
    chk("R9 stack emptied", mask, 7);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_enable();
    t_nest();
    t_boundary();
    t_same();
    t_underflow();
    t_prec();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule